// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block is a synchronous front end for an external asynchronous static RAM of 128K words by 8 bits. A client issues single-word reads and writes over a valid/ready handshake; the controller turns each request into a sequence of registered strobes on the memory side: a 17-bit address, a pair of opposite-polarity chip selects, an output-enable, a write-enable and the direction control of the shared data bus. Every strobe comes straight from a flip-flop, so no decode glitch reaches the memory.

All analog timing windows are given in nanoseconds as parameters together with the clock period. The controller turns each into a whole number of clock cycles by rounding up. A read holds the memory selected with output-enable low for the read interval and registers the bus on its last clock. A write holds write-enable low for the write interval, which covers the pulse width, the address-to-end-of-write time, the data setup time and the write cycle time. After every read, a turnaround gap with the memory deselected lets the memory release the bus before the controller can drive it.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and whenever no access is in progress, the active-low select is 1, the active-high select is 0, output-enable and write-enable (both active low) are 1, and the bus driver enable is 0.
- R2: `req_ready` is 1 only in the idle state; a request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 0 from the next cycle until the access and its recovery or turnaround have ended.
- R3: A read asserts both selects and output-enable, keeps write-enable at 1, and presents the requested address, for exactly RD_CYC cycles, where RD_CYC is the largest of the rounded-up read cycle time, address access time and output-enable access time; with defaults and a 20 ns clock RD_CYC is 5. Output-enable and write-enable are never low together.
- R4: Read data is registered from the bus on the last clock of the read interval; `rsp_valid` is 1 for exactly one cycle, starting RD_CYC clock edges after the accepting edge, with the data on `rsp_rdata`.
- R5: A write asserts both selects and pulls write-enable low for exactly WR_CYC cycles, the largest of the rounded-up write pulse width, address-to-end-of-write, data setup and write cycle times (5 with defaults at 20 ns); address and write data do not change while write-enable is low.
- R6: The bus driver enable is 1 only while write-enable is low, so the controller never drives while the memory may.
- R7: After a read, at least TURN_CYC + 1 clock cycles pass from output-enable rising to the bus driver enabling, where TURN_CYC is the rounded-up bus release time, at least 1 (2 with defaults).
- R8: Data written to an address is returned by any later read of that address until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data |
| sram_addr | output | ADDR_W | Memory address |
| sram_sel_n | output | 1 | Active-low chip select |
| sram_sel | output | 1 | Active-high chip select |
| sram_oe_n | output | 1 | Output-enable, active low |
| sram_we_n | output | 1 | Write-enable, active low |
| sram_dq_out | output | DATA_W | Data driven onto the bus |
| sram_dq_oe | output | 1 | Bus driver enable |
| sram_dq_in | input | DATA_W | Data seen on the bus |

## Verification
A small memory of 32 words is first filled with an arithmetic pattern and read back in address order, which separates address routing faults from data faults. A second pass writes the complement in descending order, each write followed at once by a read, so the read-to-write turnaround is exercised on every address and stale data would show. The memory model only returns valid data once the access time has elapsed, so a capture one cycle early reads junk, and a bus monitor measures strobe widths, the turnaround gap and driver collisions on every access.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 20,
  parameter int T_RC_NS   = 85,
  parameter int T_AA_NS   = 85,
  parameter int T_OE_NS   = 40,
  parameter int T_WC_NS   = 85,
  parameter int T_WP_NS   = 60,
  parameter int T_AW_NS   = 70,
  parameter int T_DW_NS   = 35,
  parameter int T_REL_NS  = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_sel_n,
  output logic              sram_sel,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC   = max2(1, max2(cyc(T_RC_NS), max2(cyc(T_AA_NS), cyc(T_OE_NS))));
  localparam int WR_CYC   = max2(1, max2(max2(cyc(T_WC_NS), cyc(T_WP_NS)),
                                         max2(cyc(T_AW_NS), cyc(T_DW_NS))));
  localparam int TURN_CYC = max2(1, cyc(T_REL_NS));
  localparam int MAX_CYC  = max2(RD_CYC, max2(WR_CYC, TURN_CYC));
  localparam int CW       = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_TURN} state_t;

  state_t            state;
  logic [CW-1:0]     cnt;
  logic              sel_q, oe_q, we_q, drv_q, rsp_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q, rdat_q;

  wire last_rd   = (cnt == CW'(RD_CYC - 1));
  wire last_wr   = (cnt == CW'(WR_CYC - 1));
  wire last_turn = (cnt == CW'(TURN_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      sel_q  <= 1'b0;
      oe_q   <= 1'b0;
      we_q   <= 1'b0;
      drv_q  <= 1'b0;
      rsp_q  <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      rsp_q <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            addr_q <= req_addr;
            cnt    <= '0;
            sel_q  <= 1'b1;
            if (req_write) begin
              wdat_q <= req_wdata;
              we_q   <= 1'b1;
              drv_q  <= 1'b1;
              state  <= S_WR;
            end else begin
              oe_q  <= 1'b1;
              state <= S_RD;
            end
          end
        end
        S_RD: begin
          if (last_rd) begin
            rdat_q <= sram_dq_in;
            rsp_q  <= 1'b1;
            sel_q  <= 1'b0;
            oe_q   <= 1'b0;
            cnt    <= '0;
            state  <= S_TURN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WR: begin
          if (last_wr) begin
            sel_q <= 1'b0;
            we_q  <= 1'b0;
            drv_q <= 1'b0;
            cnt   <= '0;
            state <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_TURN: begin
          if (last_turn) begin
            cnt   <= '0;
            state <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == S_IDLE);
  assign rsp_valid   = rsp_q;
  assign rsp_rdata   = rdat_q;
  assign sram_addr   = addr_q;
  assign sram_sel_n  = ~sel_q;
  assign sram_sel    = sel_q;
  assign sram_oe_n   = ~oe_q;
  assign sram_we_n   = ~we_q;
  assign sram_dq_out = wdat_q;
  assign sram_dq_oe  = drv_q;

  // cycles since output-enable last went high, saturating
  logic [CW:0] since_rd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_rd <= '1;
    else if (oe_q)                       since_rd <= '0;
    else if (since_rd != '1)             since_rd <= since_rd + 1'b1;
  end

  assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (!sel_q && !oe_q && !we_q && !drv_q));

  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_no_oe_we_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_oe_n && !sram_we_n));

  assert_rsp_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_write_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(!sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out)));

  assert_drive_only_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (!sram_we_n && !sram_sel_n && sram_sel));

  assert_turnaround_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (since_rd >= (CW+1)'(TURN_CYC)));

endmodule

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int RD_EXP = 5;
  localparam int WR_EXP = 5;
  localparam int TURN_EXP = 2;
  localparam int VALID_AGE = (85 + 10 + 19) / 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, sram_sel_n, sram_sel, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [DW-1:0] rsp_rdata, sram_dq_out, sram_dq_in;
  logic [AW-1:0] sram_addr;

  always #10 clk = ~clk;

  sram_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_sel_n(sram_sel_n), .sram_sel(sram_sel), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model
  logic [DW-1:0] mem [DEPTH];
  int rd_age = 0;
  wire chip_on = !sram_sel_n && sram_sel;
  wire mem_reading = chip_on && !sram_oe_n && sram_we_n;
  assign sram_dq_in = (mem_reading && rd_age >= VALID_AGE) ? mem[sram_addr] : 8'hEE;

  int we_len = 0, oe_len = 0, gap = 1000;
  bit drv_prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      rd_age = mem_reading ? rd_age + 1 : 0;
      if (chip_on && !sram_we_n && sram_dq_oe) mem[sram_addr] = sram_dq_out;
      if (sram_dq_oe && mem_reading) chk(0, "R6 collision", 1, 0);
      if (!sram_we_n) we_len++;
      else if (we_len > 0) begin chk(we_len == WR_EXP, "R5 write pulse", we_len, WR_EXP); we_len = 0; end
      if (!sram_oe_n) oe_len++;
      else if (oe_len > 0) begin chk(oe_len == RD_EXP, "R3 read width", oe_len, RD_EXP); oe_len = 0; end
      if (!sram_oe_n) gap = 0;
      else if (!sram_dq_oe) gap++;
      if (sram_dq_oe && !drv_prev && gap < 1000)
        chk(gap >= TURN_EXP + 1, "R7 turnaround", gap, TURN_EXP + 1);
      if (sram_dq_oe && !drv_prev) gap = 1000;
      drv_prev = sram_dq_oe;
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 busy after take", req_ready, 0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    issue(1'b1, a, d);
    chk(!sram_we_n && sram_oe_n && chip_on && sram_addr == a && sram_dq_out == d,
        "R5 write strobes", {sram_we_n, sram_oe_n, sram_addr}, {2'b01, a});
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    int k;
    issue(1'b0, a, '0);
    chk(!sram_oe_n && sram_we_n && chip_on && sram_addr == a,
        "R3 read strobes", {sram_oe_n, sram_we_n, sram_addr}, {2'b01, a});
    k = 1;
    while (!rsp_valid && k < 50) begin @(negedge clk); k++; end
    chk(k == RD_EXP + 1, "R4 read latency", k, RD_EXP + 1);
    chk(rsp_rdata == exp, "R8 read data", rsp_rdata, exp);
    @(negedge clk);
    chk(!rsp_valid, "R4 single pulse", rsp_valid, 0);
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 37 + 11) & 8'hFF);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    #35;
    chk(sram_sel_n && !sram_sel && sram_oe_n && sram_we_n && !sram_dq_oe && !rsp_valid,
        "R1 reset levels", {sram_sel_n, sram_sel, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b10110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R2 ready when idle", req_ready, 1);
    for (int a = 0; a < DEPTH; a++) do_write(AW'(a), pat(a));
    for (int a = 0; a < DEPTH; a++) do_read(AW'(a), pat(a));
    for (int a = DEPTH - 1; a >= 0; a--) begin
      do_write(AW'(a), ~pat(a));
      do_read(AW'(a), ~pat(a));
    end
    do_read(AW'(0), ~pat(0));
    do_read(AW'(DEPTH - 1), ~pat(DEPTH - 1));
    repeat (10) @(negedge clk);
    chk(sram_sel_n && !sram_sel && sram_oe_n && sram_we_n && !sram_dq_oe && req_ready,
        "R1 idle levels", {sram_sel_n, sram_sel, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b10110);
    finish_run();
  end

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end
endmodule